// File: doc/BRIEF.md
# Key-Protected Watchdog Timer with Early-Warning Interrupt

This block is a watchdog timer that software programs through a simple register port: a valid strobe, a write flag, a byte offset and 16-bit data. A 15-bit down-counter loses one count each time the `tick_en` input pulses. In the intended system that input pulses every 10 ms, so the longest interval is about 327 s. If software lets the counter run down, the block raises a maskable warning interrupt one tick early. When the counter reaches zero it pulses a reset request and records a sticky expiry status.

Every control action is protected by a 16-bit key, so a stray store cannot feed, stop or restart the timer by setting a single bit. Stopping the timer takes two keys, written to two different registers in a fixed order. Enable state and expiry status read back as coded 16-bit words. A count view reports the remaining ticks, with a flag that marks a value still settling. A debug-mode input freezes the timer unless software has set an override bit.

Top module: `wdog_keyed`

## Requirements
- R1: Writing 0xFEED at offset 0x00 loads the counter from the interval register, whether or not the timer is running. Any other value written there changes nothing.
- R2: The interval register at offset 0x04 keeps the low 15 bits of a write (writing 0xFFFF reads back 0x7FFF). It resets to 6000.
- R3: The timer stops only when 0xCAFE is written at offset 0x0C as the very next write after 0x2BAD at offset 0x08. The following all leave it running: the keys in reverse order, a wrong second value, or any other write between the two keys.
- R4: Offset 0x0C reads 0xDABE while the timer is stopped and 0x0000 while it is running. Ticks do not move the counter of a stopped timer.
- R5: Writing 0xACED at offset 0x1C starts a stopped timer. Other values written there are ignored.
- R6: The status word at offset 0x10 reads 0xCFE8 once the timer has expired and 0x0000 before that. It stays set until 0xE8B4 is written there; other values do not clear it.
- R7: Offset 0x14 reads the remaining ticks in bits 14:0. In the cycle after the counter changes, bit 15 reads 1 and bits 14:0 still hold the previous value. One cycle later bit 15 is 0 and the new value shows.
- R8: Event bit 0 at offset 0x20 is set by a tick that moves the counter from 2 to 1, or by writing 1 to bit 0 at offset 0x28. Writing 1 to bit 0 at offset 0x20 clears it. `warn_irq` is high when the event bit and mask bit 0 at offset 0x24 are both 1.
- R9: A tick that moves a running counter from 1 to 0 makes `reset_req` high for exactly one cycle. The counter then stays at 0 and further ticks raise no new request.
- R10: After reset the timer is stopped (0x0C reads 0xDABE), the interval reads 6000, and the mask, event, count and status all read 0. `warn_irq` and `reset_req` are low.
- R11: While `debug_mode` is high and bit 0 at offset 0x18 is 0, ticks leave the counter unchanged. With that bit set to 1, counting continues. Offset 0x18 reads `debug_mode` in bit 1 and the override bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as a read strobe |
| tick_en | input | 1 | One-cycle pulse per timer tick |
| debug_mode | input | 1 | High while the system is halted for debugging |
| warn_irq | output | 1 | Early-warning interrupt |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
Directed sequences send each key in its right form and in wrong forms: wrong value, wrong order, and a foreign write between the two stop keys. The read-back shows whether a key was accepted. Separate directed runs cover the ticks that move the counter from 2 to 1 and from 1 to 0, so an off-by-one in the warning or expiry decode shows as an early or missing event. A seeded random mix of ticks, feeds, interval changes, stop and start sequences, and debug toggles runs with short intervals, so expiry is reached many times. After each step the count, status and event bits are compared with a bench model. That mix shows up wrong priority between a feed and a tick, and between an expiry and a stopped or frozen timer.

// File: rtl/wdog_pkg.sv
// Package: register offsets, key values and the command strobe bundle shared
// by the watchdog submodules. Assumes a 16-bit register word.
package wdog_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = WORD_W - 1;

    localparam logic [ADDR_W-1:0] OFS_FEED   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TMO    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_ARM    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_HALT   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_CNT    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_OVR    = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RESUME = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_EVT    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_FORCE  = 6'h28;

    localparam logic [WORD_W-1:0] KEY_FEED   = 16'hFEED;
    localparam logic [WORD_W-1:0] KEY_ARM    = 16'h2BAD;
    localparam logic [WORD_W-1:0] KEY_HALT   = 16'hCAFE;
    localparam logic [WORD_W-1:0] KEY_RESUME = 16'hACED;
    localparam logic [WORD_W-1:0] KEY_CLR    = 16'hE8B4;
    localparam logic [WORD_W-1:0] CODE_OFF   = 16'hDABE;
    localparam logic [WORD_W-1:0] CODE_TRIP  = 16'hCFE8;

    typedef struct packed {
        logic feed;
        logic halt;
        logic resume;
        logic stat_clr;
        logic ev_clr;
        logic ev_force;
    } wdog_cmd_t;
endpackage

// File: rtl/wdog_keys.sv
// Module: key decoder and control registers. It turns register writes into
// one-cycle command strobes and holds the run state, interval, mask and
// debug override. Assumes one access per cycle on the register port.
module wdog_keys
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_TMO = 15'd6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output wdog_cmd_t         cmd,
    output logic              enabled,
    output logic [CNT_W-1:0]  tmo_val,
    output logic              irq_mask,
    output logic              ovr_en
);
    logic armed;

    // Decode this cycle's write into key strobes.
    always_comb begin
        cmd          = '0;
        cmd.feed     = wr_en && wr_addr == OFS_FEED   && wr_data == KEY_FEED;
        cmd.halt     = wr_en && wr_addr == OFS_HALT   && wr_data == KEY_HALT && armed;
        cmd.resume   = wr_en && wr_addr == OFS_RESUME && wr_data == KEY_RESUME;
        cmd.stat_clr = wr_en && wr_addr == OFS_STAT   && wr_data == KEY_CLR;
        cmd.ev_clr   = wr_en && wr_addr == OFS_EVT    && wr_data[0];
        cmd.ev_force = wr_en && wr_addr == OFS_FORCE  && wr_data[0];
    end

    // Arm flag: true only right after the first stop key was the last write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr_en)
            armed <= (wr_addr == OFS_ARM) && (wr_data == KEY_ARM);
    end

    // Run state: stopped at reset, stopped by the key pair, started by resume.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enabled <= 1'b0;
        else if (cmd.halt)
            enabled <= 1'b0;
        else if (cmd.resume)
            enabled <= 1'b1;
    end

    // Plain read/write control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_val  <= RST_TMO;
            irq_mask <= 1'b0;
            ovr_en   <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == OFS_TMO)  tmo_val  <= wr_data[CNT_W-1:0];
            if (wr_addr == OFS_MASK) irq_mask <= wr_data[0];
            if (wr_addr == OFS_OVR)  ovr_en   <= wr_data[0];
        end
    end
endmodule

// File: rtl/wdog_core.sv
// Module: tick down-counter with warning and expiry decode. A feed reload
// beats a tick in the same cycle; an event set beats a clear. Assumes
// tick_en is a single-cycle pulse.
module wdog_core
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             enabled,
    input  logic             debug_mode,
    input  logic             ovr_en,
    input  logic [CNT_W-1:0] tmo_val,
    input  wdog_cmd_t        cmd,
    output logic [CNT_W-1:0] cnt_q,
    output logic             evt_q,
    output logic             tripped_q,
    output logic             rst_req_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic run, dec, warn_hit, expire_hit;

    // Decide whether this cycle consumes a tick and what it reaches.
    always_comb begin
        run        = enabled && (!debug_mode || ovr_en);
        dec        = run && tick_en && (cnt_q != '0) && !cmd.feed;
        warn_hit   = dec && (cnt_q == TWO);
        expire_hit = dec && (cnt_q == ONE);
    end

    // Counter: reload on feed, otherwise step down on a live tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cmd.feed)
            cnt_q <= tmo_val;
        else if (dec)
            cnt_q <= cnt_q - ONE;
    end

    // Warning event: set by the last-but-one tick or a force write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else if (warn_hit || cmd.ev_force)
            evt_q <= 1'b1;
        else if (cmd.ev_clr)
            evt_q <= 1'b0;
    end

    // Expiry: one-cycle request plus sticky status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            tripped_q <= 1'b0;
        end else begin
            rst_req_q <= expire_hit;
            if (expire_hit)
                tripped_q <= 1'b1;
            else if (cmd.stat_clr)
                tripped_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdog_view.sv
// Module: count view. It stands in for the copy of the counter seen across
// the slow domain: it trails the live count by one cycle and flags a
// mismatch as unsettled.
module wdog_view #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_in,
    output logic [W-1:0] view_q,
    output logic         busy
);
    // Follow the live counter one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n)
            view_q <= '0;
        else
            view_q <= cnt_in;
    end

    // Unsettled while the copy differs from the live value.
    always_comb busy = (view_q != cnt_in);
endmodule

// File: rtl/wdog_keyed.sv
// Module: top of the key-protected watchdog. It wires the key decoder,
// counter core and count view together and muxes the read data. Reads
// return data combinationally in the cycle of the strobe.
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_TMO = 15'd6000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              debug_mode,
    output logic              warn_irq,
    output logic              reset_req
);
    wdog_cmd_t        cmd;
    logic             wr_en, enabled, irq_mask, ovr_en;
    logic [CNT_W-1:0] tmo_val, cnt_q, view_q;
    logic             evt_q, tripped_q, view_busy;
    logic             feed_stb, clr_stb;

    // Qualify a write and expose strobes for the checker.
    always_comb begin
        wr_en    = bus_valid && bus_write;
        feed_stb = cmd.feed;
        clr_stb  = cmd.stat_clr;
    end

    wdog_keys #(.RST_TMO(RST_TMO)) i_keys (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .cmd(cmd), .enabled(enabled), .tmo_val(tmo_val),
        .irq_mask(irq_mask), .ovr_en(ovr_en)
    );

    wdog_core i_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .enabled(enabled),
        .debug_mode(debug_mode), .ovr_en(ovr_en), .tmo_val(tmo_val),
        .cmd(cmd), .cnt_q(cnt_q), .evt_q(evt_q), .tripped_q(tripped_q),
        .rst_req_q(reset_req)
    );

    wdog_view #(.W(CNT_W)) i_view (
        .clk(clk), .rst_n(rst_n), .cnt_in(cnt_q), .view_q(view_q),
        .busy(view_busy)
    );

    // Interrupt line gated by the mask.
    always_comb warn_irq = evt_q && irq_mask;

    // Read mux: coded words for run state and status, zero for write-only.
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            case (bus_addr)
                OFS_TMO:  bus_rdata = {1'b0, tmo_val};
                OFS_HALT: bus_rdata = enabled ? '0 : CODE_OFF;
                OFS_STAT: bus_rdata = tripped_q ? CODE_TRIP : '0;
                OFS_CNT:  bus_rdata = {view_busy, view_q};
                OFS_OVR:  bus_rdata = {{(WORD_W-2){1'b0}}, debug_mode, ovr_en};
                OFS_EVT:  bus_rdata = {{(WORD_W-1){1'b0}}, evt_q};
                OFS_MASK: bus_rdata = {{(WORD_W-1){1'b0}}, irq_mask};
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdog_keyed_chk.sv
// Module: assertion checker bound to the watchdog top.
module wdog_keyed_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enabled,
    input logic             feed_stb,
    input logic             clr_stb,
    input logic             debug_mode,
    input logic             ovr_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] view_q,
    input logic             tripped_q,
    input logic             warn_irq,
    input logic             irq_mask,
    input logic             reset_req
);
    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !feed_stb) |=> $stable(cnt_q));

    p_debug_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode && !ovr_en && !feed_stb) |=> $stable(cnt_q));

    p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped_q && !clr_stb) |=> tripped_q);

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> irq_mask);

    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    p_req_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (cnt_q == '0) && tripped_q);

    p_view_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> view_q == $past(cnt_q));
endmodule

bind wdog_keyed wdog_keyed_chk i_chk (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .feed_stb(feed_stb),
    .clr_stb(clr_stb), .debug_mode(debug_mode), .ovr_en(ovr_en),
    .cnt_q(cnt_q), .view_q(view_q), .tripped_q(tripped_q),
    .warn_irq(warn_irq), .irq_mask(irq_mask), .reset_req(reset_req)
);

// File: tb/test_wdog_keyed.sv
// Bench: directed key and boundary sequences, then a seeded random mix
// checked against a bench model of the requirements.
module test_wdog_keyed;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        tick_en = 1'b0, debug_mode = 1'b0;
    logic        warn_irq, reset_req;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    bit          m_en, m_trip, m_ev, m_ovr;
    logic [14:0] m_cnt, m_tmo;

    always #2 clk = ~clk;

    wdog_keyed i_wdog_keyed (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .debug_mode(debug_mode), .warn_irq(warn_irq),
        .reset_req(reset_req)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic tick();
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic rchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    function automatic bit f_live();
        return m_en && (!debug_mode || m_ovr) && (m_cnt != 0);
    endfunction

    function automatic logic [15:0] f_halt_word();
        return m_en ? 16'h0000 : 16'hDABE;
    endfunction

    function automatic logic [15:0] f_stat_word();
        return m_trip ? 16'hCFE8 : 16'h0000;
    endfunction

    // Model-tracked tick with an immediate reset request check.
    task automatic mtick();
        bit exp_req;
        exp_req = 1'b0;
        if (f_live()) begin
            if (m_cnt == 2) m_ev = 1'b1;
            if (m_cnt == 1) begin m_trip = 1'b1; exp_req = 1'b1; end
            m_cnt = m_cnt - 1;
        end
        tick();
        chk("R9 reset_req after tick", {15'd0, reset_req}, {15'd0, exp_req});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R10 reset state
        rchk("R10 halt word", 6'h0C, 16'hDABE);
        rchk("R10 interval", 6'h04, 16'd6000);
        rchk("R10 mask", 6'h24, 16'h0000);
        rchk("R10 count", 6'h14, 16'h0000);
        rchk("R10 status", 6'h10, 16'h0000);
        rchk("R10 event", 6'h20, 16'h0000);
        chk("R10 outputs", {14'd0, warn_irq, reset_req}, 16'h0000);

        // R5 start, R1 feed
        wr(6'h1C, 16'hACED);
        rchk("R5 started", 6'h0C, 16'h0000);
        wr(6'h04, 16'd5);
        wr(6'h00, 16'hFEED);
        idle();
        rchk("R1 feed loads interval", 6'h14, 16'h0005);
        tick(); idle();
        wr(6'h00, 16'hFEEE);
        idle();
        rchk("R1 wrong feed ignored", 6'h14, 16'h0004);

        // R7 unsettled flag
        tick();
        rchk("R7 busy with old value", 6'h14, 16'h8004);
        rchk("R7 settled", 6'h14, 16'h0003);

        // R8 warning one tick early
        wr(6'h24, 16'h0001);
        tick();
        chk("R8 no early event", {15'd0, warn_irq}, 16'h0000);
        tick();
        chk("R8 irq at count 1", {15'd0, warn_irq}, 16'h0001);
        rchk("R8 event bit", 6'h20, 16'h0001);
        wr(6'h20, 16'h0001);
        rchk("R8 event cleared", 6'h20, 16'h0000);

        // R9 expiry
        chk("R9 no request before zero", {15'd0, reset_req}, 16'h0000);
        tick();
        chk("R9 request pulse", {15'd0, reset_req}, 16'h0001);
        idle();
        chk("R9 request ends", {15'd0, reset_req}, 16'h0000);
        rchk("R6 tripped status", 6'h10, 16'hCFE8);
        rchk("R9 count at zero", 6'h14, 16'h0000);
        tick();
        chk("R9 no second request", {15'd0, reset_req}, 16'h0000);

        // R6 status clear key
        wr(6'h10, 16'h1234);
        rchk("R6 wrong clear ignored", 6'h10, 16'hCFE8);
        wr(6'h10, 16'hE8B4);
        rchk("R6 cleared", 6'h10, 16'h0000);

        // R3 stop sequence
        wr(6'h04, 16'd20);
        wr(6'h00, 16'hFEED);
        wr(6'h0C, 16'hCAFE); wr(6'h08, 16'h2BAD);
        rchk("R3 reversed keys", 6'h0C, 16'h0000);
        wr(6'h0C, 16'hCAFF);
        rchk("R3 wrong second key", 6'h0C, 16'h0000);
        wr(6'h08, 16'h2BAD); wr(6'h04, 16'd20); wr(6'h0C, 16'hCAFE);
        rchk("R3 write between keys", 6'h0C, 16'h0000);
        wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE);
        rchk("R4 stopped word", 6'h0C, 16'hDABE);
        tick(); idle();
        rchk("R4 stopped counter holds", 6'h14, 16'd20);

        // R5 wrong start key
        wr(6'h1C, 16'h1234);
        rchk("R5 wrong key ignored", 6'h0C, 16'hDABE);
        wr(6'h1C, 16'hACED);
        rchk("R5 restarted", 6'h0C, 16'h0000);

        // R11 debug freeze and override
        debug_mode = 1'b1;
        rchk("R11 debug indication", 6'h18, 16'h0002);
        tick(); idle();
        rchk("R11 frozen", 6'h14, 16'd20);
        wr(6'h18, 16'h0001);
        rchk("R11 override bit", 6'h18, 16'h0003);
        tick(); idle();
        rchk("R11 counts with override", 6'h14, 16'd19);
        debug_mode = 1'b0;
        wr(6'h18, 16'h0000);

        // R8 force and mask
        wr(6'h24, 16'h0000);
        wr(6'h28, 16'h0001);
        rchk("R8 forced event", 6'h20, 16'h0001);
        chk("R8 masked irq", {15'd0, warn_irq}, 16'h0000);
        wr(6'h24, 16'h0001);
        chk("R8 unmasked irq", {15'd0, warn_irq}, 16'h0001);
        wr(6'h20, 16'h0001);

        // R2 width
        wr(6'h04, 16'hFFFF);
        rchk("R2 interval masked", 6'h04, 16'h7FFF);

        // random mix
        wr(6'h04, 16'd6); wr(6'h00, 16'hFEED);
        m_en = 1'b1; m_trip = 1'b0; m_ev = 1'b0; m_ovr = 1'b0;
        m_tmo = 15'd6; m_cnt = 15'd6;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 4) mtick();
            else if (op == 5) begin wr(6'h00, 16'hFEED); m_cnt = m_tmo; end
            else if (op == 6) begin
                m_tmo = 15'($urandom_range(1, 12));
                wr(6'h04, {1'b0, m_tmo});
            end
            else if (op == 7) debug_mode = ~debug_mode;
            else if (op == 8) begin wr(6'h08, 16'h2BAD); wr(6'h0C, 16'hCAFE); m_en = 1'b0; end
            else begin wr(6'h1C, 16'hACED); m_en = 1'b1; end
            idle();
            rchk("R7 random count", 6'h14, {1'b0, m_cnt});
            rchk("R6 random status", 6'h10, f_stat_word());
            rchk("R4 random run word", 6'h0C, f_halt_word());
            rchk("R8 random event", 6'h20, {15'd0, m_ev});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule